// File: doc/BRIEF.md
# Accumulator ALU with BCD adjust

This block is the byte-wide arithmetic and logic datapath of an accumulator-based microcontroller core. On each cycle in which `op_valid_i` is high, it takes the current accumulator, a second operand byte, the B register and the carry, auxiliary-carry and overflow flags. It applies the operation chosen by `op_i` and registers the new accumulator, B value, operand byte and flags. The result appears at the outputs on the clock edge that samples the request.

The operation set covers several groups. Arithmetic: carry-chained add and subtract, packed-BCD decimal correction, increment and decrement. Bitwise: AND, OR, XOR, complement and clear. Data movement: rotates with and without the carry, nibble swap and a low-nibble exchange with the operand byte. Wide operations: multiply and divide, which split a two-byte result across A and B.

The surrounding core keeps the architectural registers. It feeds the registered results back as the next inputs, so a multi-byte add is two back-to-back requests with `cy_o` returned to `cy_i`. Decode, operand fetch, memory and the program counter are handled elsewhere.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, every output is 0 and `res_valid_o` is 0. Release passes through a two-stage synchronizer.
- R2: Add is op 0 and returns A+operand. Add-with-carry is op 1 and returns A+operand+carry-in. The sum is truncated to 8 bits. Carry = carry out of bit 7, auxiliary carry = carry out of bit 3, overflow = signed two's-complement overflow.
- R3: Subtract-with-borrow is op 2 and returns A−operand−carry-in. Carry = borrow out of bit 7, auxiliary carry = borrow out of bit 3, overflow = signed overflow.
- R4: Decimal adjust is op 3. If the low nibble is above 9 or auxiliary carry is set, 06h is added, and a carry from this step sets carry. Then, if the high nibble is above 9 or carry is set, 60h is added, and a carry from this step also sets carry. Carry is never cleared, and auxiliary carry and overflow pass through.
- R5: Increment (op 4) and decrement (op 5) wrap modulo 256. AND (op 6), OR (op 7) and XOR (op 8) combine A with the operand. Complement (op 9) inverts A and clear (op 10) zeroes A. None of these ops changes any flag.
- R6: Rotate left (op 11) and rotate right (op 13) move A one place and leave carry unchanged. Rotate left through carry (op 12) and rotate right through carry (op 14) shift the old carry into the vacated bit and put the outgoing bit into carry.
- R7: Swap (op 15) exchanges bits 7:4 and 3:0 of A. Flags are unchanged.
- R8: Low-nibble exchange (op 16) swaps A[3:0] with operand[3:0]. Both upper nibbles are kept. The new operand byte appears on `opnd_o`, and flags are unchanged.
- R9: Multiply (op 17) forms A×B. It returns the low byte on `acc_o` and the high byte on `b_o`. Overflow is set when the product exceeds 255, carry is cleared and auxiliary carry passes through.
- R10: Divide (op 18) returns the quotient A/B on `acc_o` and the remainder on `b_o`, and clears carry and overflow. With B = 0 it sets overflow, clears carry and returns A and B unchanged.
- R11: Outputs change only on an edge where `op_valid_i` is high. `res_valid_o` is high exactly in the cycle after such an edge.
- R12: `b_o` equals the B input for every op other than 17 and 18. `opnd_o` equals the operand input for every op other than 16. Unassigned op codes leave A and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Execute request; clock enable of the result registers |
| op_i | input | 5 | Operation code |
| acc_i | input | DATA_W | Current accumulator |
| opnd_i | input | DATA_W | Second operand byte |
| b_i | input | DATA_W | Current B register |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary-carry flag in |
| ov_i | input | 1 | Overflow flag in |
| acc_o | output | DATA_W | New accumulator |
| b_o | output | DATA_W | New B register |
| opnd_o | output | DATA_W | Operand byte to write back |
| cy_o | output | 1 | New carry |
| ac_o | output | 1 | New auxiliary carry |
| ov_o | output | 1 | New overflow |
| res_valid_o | output | 1 | Result registered on the previous edge |

## Verification
The bench builds the block with its default width of 8 bits. At that width the nibble boundary sits at bit 3, and the decimal-adjust constants are exactly 06h and 60h. Byte-wrap corners such as FFh+1, 80h−1 and a product of exactly 256 are then reachable with literal vectors. A fixed vector table drives every op code through its flag corners, including decimal adjust that carries out of the first correction step and division by zero. Directed sequences then chain a two-byte add through the carry, follow an add with decimal adjust, and check holding while idle and reset during operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_DA   = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_CLR  = 5'd10,
    OP_RL   = 5'd11,
    OP_RLC  = 5'd12,
    OP_RR   = 5'd13,
    OP_RRC  = 5'd14,
    OP_SWAP = 5'd15,
    OP_XCHD = 5'd16,
    OP_MUL  = 5'd17,
    OP_DIV  = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
// Carry-chained adder/subtractor with half-word and signed-overflow flags.
module acc_alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] bx;
  logic              cx;
  logic [DATA_W:0]   full_sum;
  logic [NIB:0]      low_sum;

  always_comb begin
    bx       = sub_i ? ~b_i : b_i;
    cx       = sub_i ? ~cin_i : cin_i;
    full_sum = {1'b0, a_i} + {1'b0, bx} + {{DATA_W{1'b0}}, cx};
    low_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cx};
    res_o    = full_sum[DATA_W-1:0];
    // For subtraction, no carry out means a borrow occurred.
    cy_o     = sub_i ? ~full_sum[DATA_W] : full_sum[DATA_W];
    ac_o     = sub_i ? ~low_sum[NIB] : low_sum[NIB];
    ov_o     = (a_i[DATA_W-1] == bx[DATA_W-1]) &&
               (full_sum[DATA_W-1] != a_i[DATA_W-1]);
  end
endmodule

// File: rtl/acc_alu_bcd.sv
// Two-step packed-BCD correction of an accumulator after an add.
module acc_alu_bcd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  localparam int NIB = DATA_W / 2;
  localparam logic [NIB-1:0]  NINE  = NIB'(9);
  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << NIB;

  logic              fix_lo;
  logic              fix_hi;
  logic              c_mid;
  logic [DATA_W:0]   step1;
  logic [DATA_W:0]   step2;

  always_comb begin
    fix_lo = (a_i[NIB-1:0] > NINE) | ac_i;
    step1  = {1'b0, a_i} + (fix_lo ? LO_FIX : '0);
    c_mid  = cy_i | step1[DATA_W];
    fix_hi = (step1[DATA_W-1:NIB] > NINE) | c_mid;
    step2  = {1'b0, step1[DATA_W-1:0]} + (fix_hi ? HI_FIX : '0);
    res_o  = step2[DATA_W-1:0];
    cy_o   = c_mid | step2[DATA_W];
  end
endmodule

// File: rtl/acc_alu_perm.sv
// Rotates, nibble swap and low-nibble exchange.
module acc_alu_perm #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] rl_o,
  output logic [DATA_W-1:0] rr_o,
  output logic [DATA_W-1:0] rlc_o,
  output logic [DATA_W-1:0] rrc_o,
  output logic              cy_left_o,
  output logic              cy_right_o,
  output logic [DATA_W-1:0] swap_o,
  output logic [DATA_W-1:0] xa_o,
  output logic [DATA_W-1:0] xm_o
);
  localparam int NIB = DATA_W / 2;

  always_comb begin
    rl_o       = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
    rr_o       = {a_i[0], a_i[DATA_W-1:1]};
    rlc_o      = {a_i[DATA_W-2:0], cy_i};
    rrc_o      = {cy_i, a_i[DATA_W-1:1]};
    cy_left_o  = a_i[DATA_W-1];
    cy_right_o = a_i[0];
    swap_o     = {a_i[NIB-1:0], a_i[DATA_W-1:NIB]};
    xa_o       = {a_i[DATA_W-1:NIB], m_i[NIB-1:0]};
    xm_o       = {m_i[DATA_W-1:NIB], a_i[NIB-1:0]};
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
// Unsigned multiply and restoring divide, one subtract stage per quotient bit.
module acc_alu_muldiv #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] prod_lo_o,
  output logic [DATA_W-1:0] prod_hi_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o
);
  localparam int PW = 2 * DATA_W;

  logic [PW-1:0]     prod;
  logic [DATA_W-1:0] part [DATA_W+1];

  assign prod      = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  assign prod_lo_o = prod[DATA_W-1:0];
  assign prod_hi_o = prod[PW-1:DATA_W];

  assign part[DATA_W] = '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    localparam int K = DATA_W - 1 - i;
    logic [DATA_W:0] trial;
    logic [DATA_W:0] diff;
    assign trial     = {part[K+1], a_i[K]};
    assign diff      = trial - {1'b0, b_i};
    assign quot_o[K] = ~diff[DATA_W];
    assign part[K]   = diff[DATA_W] ? trial[DATA_W-1:0] : diff[DATA_W-1:0];
  end

  assign rem_o = part[0];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  input  logic              ac_i,
  input  logic              ov_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] opnd_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o,
  output logic              res_valid_o
);
  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  // Functional units.
  logic              as_sub;
  logic [DATA_W-1:0] as_res;
  logic              as_cy, as_ac, as_ov;

  assign as_sub = (op_i == OP_SUBB);

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i ((op_i == OP_ADD) ? 1'b0 : cy_i),
    .sub_i (as_sub),
    .res_o (as_res),
    .cy_o  (as_cy),
    .ac_o  (as_ac),
    .ov_o  (as_ov)
  );

  logic [DATA_W-1:0] da_res;
  logic              da_cy;

  acc_alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .a_i   (acc_i),
    .cy_i  (cy_i),
    .ac_i  (ac_i),
    .res_o (da_res),
    .cy_o  (da_cy)
  );

  logic [DATA_W-1:0] rl_v, rr_v, rlc_v, rrc_v, swap_v, xa_v, xm_v;
  logic              cy_l, cy_r;

  acc_alu_perm #(.DATA_W(DATA_W)) u_perm (
    .a_i        (acc_i),
    .m_i        (opnd_i),
    .cy_i       (cy_i),
    .rl_o       (rl_v),
    .rr_o       (rr_v),
    .rlc_o      (rlc_v),
    .rrc_o      (rrc_v),
    .cy_left_o  (cy_l),
    .cy_right_o (cy_r),
    .swap_o     (swap_v),
    .xa_o       (xa_v),
    .xm_o       (xm_v)
  );

  logic [DATA_W-1:0] p_lo, p_hi, q_v, r_v;

  acc_alu_muldiv #(.DATA_W(DATA_W)) u_muldiv (
    .a_i       (acc_i),
    .b_i       (b_i),
    .prod_lo_o (p_lo),
    .prod_hi_o (p_hi),
    .quot_o    (q_v),
    .rem_o     (r_v)
  );

  // Next-state selection.
  alu_op_e           op_e;
  logic [DATA_W-1:0] acc_n, b_n, mem_n;
  alu_flags_t        fl_n;

  always_comb begin
    op_e  = alu_op_e'(op_i);
    acc_n = acc_i;
    b_n   = b_i;
    mem_n = opnd_i;
    fl_n  = '{cy: cy_i, ac: ac_i, ov: ov_i};
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_n = as_res;
        fl_n  = '{cy: as_cy, ac: as_ac, ov: as_ov};
      end
      OP_DA: begin
        acc_n   = da_res;
        fl_n.cy = da_cy;
      end
      OP_INC:  acc_n = acc_i + DATA_W'(1);
      OP_DEC:  acc_n = acc_i - DATA_W'(1);
      OP_AND:  acc_n = acc_i & opnd_i;
      OP_OR:   acc_n = acc_i | opnd_i;
      OP_XOR:  acc_n = acc_i ^ opnd_i;
      OP_CPL:  acc_n = ~acc_i;
      OP_CLR:  acc_n = '0;
      OP_RL:   acc_n = rl_v;
      OP_RR:   acc_n = rr_v;
      OP_RLC: begin
        acc_n   = rlc_v;
        fl_n.cy = cy_l;
      end
      OP_RRC: begin
        acc_n   = rrc_v;
        fl_n.cy = cy_r;
      end
      OP_SWAP: acc_n = swap_v;
      OP_XCHD: begin
        acc_n = xa_v;
        mem_n = xm_v;
      end
      OP_MUL: begin
        acc_n   = p_lo;
        b_n     = p_hi;
        fl_n.cy = 1'b0;
        fl_n.ov = |p_hi;
      end
      OP_DIV: begin
        fl_n.cy = 1'b0;
        if (b_i == '0) begin
          fl_n.ov = 1'b1;
        end else begin
          acc_n   = q_v;
          b_n     = r_v;
          fl_n.ov = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // Result registers, enabled by the request strobe.
  logic [DATA_W-1:0] acc_q, b_q, mem_q;
  alu_flags_t        fl_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q <= '0;
      b_q   <= '0;
      mem_q <= '0;
      fl_q  <= '0;
    end else if (op_valid_i) begin
      acc_q <= acc_n;
      b_q   <= b_n;
      mem_q <= mem_n;
      fl_q  <= fl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) vld_q <= 1'b0;
    else          vld_q <= op_valid_i;
  end

  assign acc_o       = acc_q;
  assign b_o         = b_q;
  assign opnd_o      = mem_q;
  assign cy_o        = fl_q.cy;
  assign ac_o        = fl_q.ac;
  assign ov_o        = fl_q.ov;
  assign res_valid_o = vld_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid_i,
  input logic [4:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cy_i,
  input logic              ac_i,
  input logic              ov_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] b_o,
  input logic [DATA_W-1:0] opnd_o,
  input logic              cy_o,
  input logic              ac_o,
  input logic              ov_o,
  input logic              res_valid_o
);
  localparam int NIB = DATA_W / 2;

  logic go;
  assign go = op_valid_i;

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> res_valid_o);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!res_valid_o && $stable(acc_o) && $stable(b_o) && $stable(opnd_o) &&
             $stable(cy_o) && $stable(ac_o) && $stable(ov_o)));

  assert_flags_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op_i >= OP_INC) && (op_i <= OP_CLR)) |=>
      (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

  assert_plain_rot_cy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op_i == OP_RL || op_i == OP_RR)) |=> (cy_o == $past(cy_i)));

  assert_rlc_cy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i == OP_RLC) |=> (cy_o == $past(acc_i[DATA_W-1]) && acc_o[0] == $past(cy_i)));

  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i == OP_SWAP) |=>
      (acc_o == {$past(acc_i[NIB-1:0]), $past(acc_i[DATA_W-1:NIB])}));

  assert_xchd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i == OP_XCHD) |=>
      (acc_o[DATA_W-1:NIB] == $past(acc_i[DATA_W-1:NIB]) &&
       opnd_o[DATA_W-1:NIB] == $past(opnd_i[DATA_W-1:NIB]) &&
       acc_o[NIB-1:0] == $past(opnd_i[NIB-1:0]) &&
       opnd_o[NIB-1:0] == $past(acc_i[NIB-1:0])));

  assert_mul_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i == OP_MUL) |=> (!cy_o && (ov_o == (b_o != '0))));

  assert_div_rem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i == OP_DIV && b_i != '0) |=> (!cy_o && !ov_o && b_o < $past(b_i)));

  assert_div_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i == OP_DIV && b_i == '0) |=> (ov_o && !cy_o && acc_o == $past(acc_i)));

  assert_b_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_i != OP_MUL && op_i != OP_DIV) |=> (b_o == $past(b_i)));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .op_valid_i  (op_valid_i),
  .op_i        (op_i),
  .acc_i       (acc_i),
  .opnd_i      (opnd_i),
  .b_i         (b_i),
  .cy_i        (cy_i),
  .ac_i        (ac_i),
  .ov_i        (ov_i),
  .acc_o       (acc_o),
  .b_o         (b_o),
  .opnd_o      (opnd_o),
  .cy_o        (cy_o),
  .ac_o        (ac_o),
  .ov_o        (ov_o),
  .res_valid_o (res_valid_o)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid_i;
  logic [4:0] op_i;
  logic [7:0] acc_i, opnd_i, b_i;
  logic       cy_i, ac_i, ov_i;
  logic [7:0] acc_o, b_o, opnd_o;
  logic       cy_o, ac_o, ov_o, res_valid_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  acc_alu #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .b_i(b_i),
    .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
    .acc_o(acc_o), .b_o(b_o), .opnd_o(opnd_o),
    .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .res_valid_o(res_valid_o)
  );

  // Entry: {req[4], op[5], a, opnd, b, flags{cy,ac,ov}, exp_a, exp_b, exp_opnd, exp_flags}
  localparam int NV = 33;
  localparam logic [62:0] VEC [NV] = '{
    // R2 add / add with carry
    {4'd2, 5'd0, 8'h38, 8'h45, 8'h00, 3'b000, 8'h7D, 8'h00, 8'h45, 3'b000},
    {4'd2, 5'd0, 8'h80, 8'h80, 8'h11, 3'b000, 8'h00, 8'h11, 8'h80, 3'b101},
    {4'd2, 5'd0, 8'h0F, 8'h01, 8'h00, 3'b000, 8'h10, 8'h00, 8'h01, 3'b010},
    {4'd2, 5'd1, 8'hFF, 8'h00, 8'h00, 3'b100, 8'h00, 8'h00, 8'h00, 3'b110},
    {4'd2, 5'd1, 8'h7F, 8'h00, 8'h00, 3'b100, 8'h80, 8'h00, 8'h00, 3'b011},
    // R3 subtract with borrow
    {4'd3, 5'd2, 8'h10, 8'h01, 8'h00, 3'b000, 8'h0F, 8'h00, 8'h01, 3'b010},
    {4'd3, 5'd2, 8'h00, 8'h01, 8'h00, 3'b000, 8'hFF, 8'h00, 8'h01, 3'b110},
    {4'd3, 5'd2, 8'h80, 8'h01, 8'h00, 3'b000, 8'h7F, 8'h00, 8'h01, 3'b011},
    {4'd3, 5'd2, 8'h05, 8'h03, 8'h00, 3'b100, 8'h01, 8'h00, 8'h03, 3'b000},
    // R4 decimal adjust
    {4'd4, 5'd3, 8'h7D, 8'h00, 8'h00, 3'b000, 8'h83, 8'h00, 8'h00, 3'b000},
    {4'd4, 5'd3, 8'h9A, 8'h00, 8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 3'b100},
    {4'd4, 5'd3, 8'h10, 8'h00, 8'h00, 3'b010, 8'h16, 8'h00, 8'h00, 3'b010},
    {4'd4, 5'd3, 8'h00, 8'h00, 8'h00, 3'b100, 8'h60, 8'h00, 8'h00, 3'b100},
    {4'd4, 5'd3, 8'hFA, 8'h00, 8'h00, 3'b000, 8'h60, 8'h00, 8'h00, 3'b100},
    // R5 inc/dec and bitwise ops, flags kept
    {4'd5, 5'd4, 8'hFF, 8'h00, 8'h00, 3'b111, 8'h00, 8'h00, 8'h00, 3'b111},
    {4'd5, 5'd5, 8'h00, 8'h00, 8'h00, 3'b000, 8'hFF, 8'h00, 8'h00, 3'b000},
    {4'd5, 5'd6, 8'hF0, 8'h3C, 8'h00, 3'b101, 8'h30, 8'h00, 8'h3C, 3'b101},
    {4'd5, 5'd7, 8'hF0, 8'h0F, 8'h00, 3'b010, 8'hFF, 8'h00, 8'h0F, 3'b010},
    // R12 B passes through a non-multiply op
    {4'd12, 5'd8, 8'hAA, 8'hFF, 8'h77, 3'b000, 8'h55, 8'h77, 8'hFF, 3'b000},
    {4'd5, 5'd9, 8'h5A, 8'h00, 8'h00, 3'b100, 8'hA5, 8'h00, 8'h00, 3'b100},
    {4'd5, 5'd10, 8'h5A, 8'h00, 8'h00, 3'b011, 8'h00, 8'h00, 8'h00, 3'b011},
    // R6 rotates
    {4'd6, 5'd11, 8'h81, 8'h00, 8'h00, 3'b000, 8'h03, 8'h00, 8'h00, 3'b000},
    {4'd6, 5'd12, 8'h81, 8'h00, 8'h00, 3'b000, 8'h02, 8'h00, 8'h00, 3'b100},
    {4'd6, 5'd13, 8'h81, 8'h00, 8'h00, 3'b100, 8'hC0, 8'h00, 8'h00, 3'b100},
    {4'd6, 5'd14, 8'h81, 8'h00, 8'h00, 3'b000, 8'h40, 8'h00, 8'h00, 3'b100},
    {4'd6, 5'd14, 8'h00, 8'h00, 8'h00, 3'b100, 8'h80, 8'h00, 8'h00, 3'b000},
    // R7 swap
    {4'd7, 5'd15, 8'h3C, 8'h00, 8'h00, 3'b000, 8'hC3, 8'h00, 8'h00, 3'b000},
    // R8 low-nibble exchange
    {4'd8, 5'd16, 8'h12, 8'hAB, 8'h00, 3'b101, 8'h1B, 8'h00, 8'hA2, 3'b101},
    // R9 multiply
    {4'd9, 5'd17, 8'h10, 8'h00, 8'h10, 3'b110, 8'h00, 8'h01, 8'h00, 3'b011},
    {4'd9, 5'd17, 8'h0F, 8'h00, 8'h11, 3'b101, 8'hFF, 8'h00, 8'h00, 3'b000},
    // R10 divide, including zero divisor
    {4'd10, 5'd18, 8'h64, 8'h00, 8'h07, 3'b100, 8'h0E, 8'h02, 8'h00, 3'b000},
    {4'd10, 5'd18, 8'h05, 8'h00, 8'h00, 3'b100, 8'h05, 8'h00, 8'h00, 3'b001},
    {4'd10, 5'd18, 8'hFF, 8'h00, 8'h01, 3'b001, 8'hFF, 8'h00, 8'h00, 3'b000}
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] b, input logic [2:0] fl);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = d; b_i = b;
    {cy_i, ac_i, ov_i} = fl;
    op_valid_i = 1'b1;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200us;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    op_valid_i = 1'b0; op_i = '0; acc_i = '0; opnd_i = '0; b_i = '0;
    cy_i = 1'b0; ac_i = 1'b0; ov_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "acc", acc_o, 8'h00);
    check("R1", "flags+valid", {4'b0, cy_o, ac_o, ov_o, res_valid_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[62:59]);
      apply(v[58:54], v[53:46], v[45:38], v[37:30], v[29:27]);
      check("R11", "res_valid", {7'b0, res_valid_o}, 8'h01);
      check(rq, "acc", acc_o, v[26:19]);
      check(rq, "b", b_o, v[18:11]);
      check(rq, "opnd", opnd_o, v[10:3]);
      check(rq, "flags cy,ac,ov", {5'b0, cy_o, ac_o, ov_o}, {5'b0, v[2:0]});
    end

    // R2 two-byte add chained through carry: 12F0h + 0145h = 1435h
    apply(5'd0, 8'hF0, 8'h45, 8'h00, 3'b000);
    check("R2", "low byte", acc_o, 8'h35);
    check("R2", "low carry", {7'b0, cy_o}, 8'h01);
    apply(5'd1, 8'h12, 8'h01, 8'h00, {cy_o, 2'b00});
    check("R2", "high byte", acc_o, 8'h14);
    check("R2", "high carry", {7'b0, cy_o}, 8'h00);

    // R4 add followed by decimal adjust: 29 + 18 = 47 in BCD
    apply(5'd0, 8'h29, 8'h18, 8'h00, 3'b000);
    check("R2", "bcd sum aux carry", {7'b0, ac_o}, 8'h01);
    apply(5'd3, acc_o, 8'h00, 8'h00, {cy_o, ac_o, ov_o});
    check("R4", "adjusted", acc_o, 8'h47);
    check("R4", "carry", {7'b0, cy_o}, 8'h00);

    // R11 idle: changing inputs without a request leaves outputs alone
    apply(5'd6, 8'hC3, 8'h0F, 8'h21, 3'b010);
    @(negedge clk);
    op_i = 5'd10; acc_i = 8'h99; b_i = 8'h44; opnd_i = 8'h55; cy_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "held acc", acc_o, 8'h03);
    check("R11", "held b", b_o, 8'h21);
    check("R11", "held cy", {7'b0, cy_o}, 8'h00);
    check("R11", "valid low", {7'b0, res_valid_o}, 8'h00);

    // R12 unassigned op code keeps A and flags
    apply(5'd31, 8'h6E, 8'h11, 8'h22, 3'b101);
    check("R12", "unassigned acc", acc_o, 8'h6E);
    check("R12", "unassigned flags", {5'b0, cy_o, ac_o, ov_o}, 8'h05);

    // R1 reset during operation clears outputs at once
    apply(5'd4, 8'h41, 8'h00, 8'h00, 3'b111);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "async acc", acc_o, 8'h00);
    check("R1", "async flags", {5'b0, cy_o, ac_o, ov_o}, 8'h00);
    do_reset();
    apply(5'd15, 8'hA5, 8'h00, 8'h00, 3'b000);
    check("R7", "after reset", acc_o, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule